// File: doc/BRIEF.md
# Segmented Address Adder with Index Post-Update

This block forms the 20-bit physical address of a memory access from a 16-bit segment and a 16-bit offset, using one dedicated 16-bit adder. In the first preparatory state (start strobe) the segment goes to one adder operand. The offset goes to the other operand shifted right by four, so its low four bits are dropped there. Those four bits are held in a separate one-cycle delay. In the second preparatory state (form strobe) the sum becomes bits 19:4 of the address and the delayed nibble becomes bits 3:0. Both halves are registered onto the outputs.

In the otherwise idle states of a bus cycle the same adder post-updates the index register, which the start strobe loads with the offset. A load strobe feeds the index and a small signed step constant into the adder. A write strobe, qualified by an update enable, writes the sum back. The sum is taken off the left-shifted 20-bit result through a right shift by four, which cancels the adder's output shift. A separate registered bus bridge converts between a 20-bit internal bus and a 16-bit register bus in one of three modes: straight, byte-swapped, or shifted by four.

Top module: `sa_seg_addr`

## Requirements
- R1: While `rst` is high, and after it falls until a strobe acts, every output is zero.
- R2: Assert `st_start_i` on one clock and `st_form_i` on the next. After that second clock edge, {`addr_hi_o`,`addr_lo_o`} equals (segment*16 + offset) mod 2^20, with the segment and offset sampled on the start clock. The result wraps past 0xFFFFF.
- R3: `addr_lo_o` comes from offset bits 3:0 sampled on the start clock, even if `ofs_i` changes before the form clock.
- R4: The address outputs change only on a clock where `st_form_i` is high.
- R5: The clock edge that samples `st_start_i` loads the index register (`idx_o`) with `ofs_i`.
- R6: The step constant selected by `ksel_i` = k is k-3 for k in 0..5, which gives -3..+2. Codes 6 and 7 give 0.
- R7: Assert `st_upd_ld_i` on one clock, then `st_upd_wr_i` with `upd_en_i` on the next. After that edge `idx_o` equals (index + step) mod 2^16.
- R8: A write strobe without `upd_en_i` leaves `idx_o` unchanged. `idx_o` changes only on a start edge or an enabled write edge.
- R9: Bridge mode 0 (direct), and also the spare mode 3, gives `br_rbus_o` = `br_ibus_i`[15:0] and `br_ibus_o` = {4'h0, `br_rbus_i`}. The result appears one clock after the inputs are sampled.
- R10: Bridge mode 1 (swap) gives `br_rbus_o` = `br_ibus_i`[15:0] with its two bytes exchanged, and `br_ibus_o` = {4'h0, `br_rbus_i` with its two bytes exchanged}. The latency is one clock.
- R11: Bridge mode 2 (shift) gives `br_rbus_o` = `br_ibus_i`[19:4] and `br_ibus_o` = {`br_rbus_i`, 4'h0}. The latency is one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_i | input | 16 | Segment value |
| ofs_i | input | 16 | Offset value, also loaded as the index |
| st_start_i | input | 1 | First preparatory state: load the operands and the nibble |
| st_form_i | input | 1 | Second preparatory state: publish the address |
| st_upd_ld_i | input | 1 | Load the index and the step into the adder |
| st_upd_wr_i | input | 1 | Write the sum back to the index |
| upd_en_i | input | 1 | Enables the write-back |
| ksel_i | input | 3 | Step constant select |
| br_mode_i | input | 2 | Bridge mode: 0 direct, 1 swap, 2 shift, 3 as direct |
| br_rbus_i | input | 16 | Register-bus value into the bridge |
| br_ibus_i | input | 20 | Internal-bus value into the bridge |
| addr_lo_o | output | 4 | Physical address bits 3:0 |
| addr_hi_o | output | 16 | Physical address bits 19:4 |
| idx_o | output | 16 | Index register |
| br_rbus_o | output | 16 | Bridge result toward the register bus |
| br_ibus_o | output | 20 | Bridge result toward the internal bus |

## Verification
The address is due one edge after the form strobe, which is two edges after the start strobe. The index is due one edge after a start strobe, or two edges after the update-load strobe. The bridge results are due one edge after their inputs. The driver stamps each expected value with the cycle count at which it falls due. The monitor compares it at the falling edge of exactly that cycle, so every comparison lands half a period after the register update. Repeated address checks with no form strobe cover holding. The offset is changed between the start and form clocks to test the nibble capture.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic [1:0] {
    BR_DIRECT = 2'd0,
    BR_SWAP   = 2'd1,
    BR_SHIFT  = 2'd2,
    BR_SPARE  = 2'd3
  } br_mode_e;
endpackage

// File: rtl/sa_step_rom.sv
// Signed step constants for the index post-update, computed from the code.
module sa_step_rom #(
  parameter int W      = 16,
  parameter int SEL_W  = 3,
  parameter int K_MIN  = -3,
  parameter int K_MAX  = 2
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]     k_o
);
  int v;
  always_comb begin
    v = int'(sel_i) + K_MIN;
    if (v > K_MAX) k_o = '0;
    else           k_o = W'(v);
  end
endmodule

// File: rtl/sa_addr_adder.sv
// Shared adder with registered operands; segment load has priority.
module sa_addr_adder #(
  parameter int W  = 16,
  parameter int SH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_seg_i,
  input  logic         ld_upd_i,
  input  logic [W-1:0] seg_i,
  input  logic [W-1:0] ofs_i,
  input  logic [W-1:0] idx_i,
  input  logic [W-1:0] k_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] b_q, c_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_q <= '0;
      c_q <= '0;
    end else if (ld_seg_i) begin
      b_q <= seg_i;
      c_q <= ofs_i >> SH;
    end else if (ld_upd_i) begin
      b_q <= idx_i;
      c_q <= k_i;
    end
  end

  assign sum_o = b_q + c_q;
endmodule

// File: rtl/sa_bridge.sv
// Combinational converter between the register bus and the internal bus.
module sa_bridge #(
  parameter int RW = 16,
  parameter int SH = 4,
  localparam int IW = RW + SH,
  localparam int HB = RW / 2
) (
  input  sa_pkg::br_mode_e mode_i,
  input  logic [RW-1:0]    r_i,
  input  logic [IW-1:0]    i_i,
  output logic [RW-1:0]    r_o,
  output logic [IW-1:0]    i_o
);
  logic [RW-1:0] i_low_sw, r_sw;
  assign i_low_sw = {i_i[HB-1:0], i_i[RW-1:HB]};
  assign r_sw     = {r_i[HB-1:0], r_i[RW-1:HB]};

  always_comb begin
    case (mode_i)
      sa_pkg::BR_SWAP: begin
        r_o = i_low_sw;
        i_o = {{SH{1'b0}}, r_sw};
      end
      sa_pkg::BR_SHIFT: begin
        r_o = i_i[IW-1:SH];
        i_o = {r_i, {SH{1'b0}}};
      end
      default: begin
        r_o = i_i[RW-1:0];
        i_o = {{SH{1'b0}}, r_i};
      end
    endcase
  end
endmodule

// File: rtl/sa_seg_addr.sv
module sa_seg_addr #(
  parameter int SEG_W  = 16,
  parameter int SH     = 4,
  parameter int KSEL_W = 3,
  localparam int PA_W  = SEG_W + SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [SEG_W-1:0]  ofs_i,
  input  logic              st_start_i,
  input  logic              st_form_i,
  input  logic              st_upd_ld_i,
  input  logic              st_upd_wr_i,
  input  logic              upd_en_i,
  input  logic [KSEL_W-1:0] ksel_i,
  input  logic [1:0]        br_mode_i,
  input  logic [SEG_W-1:0]  br_rbus_i,
  input  logic [PA_W-1:0]   br_ibus_i,
  output logic [SH-1:0]     addr_lo_o,
  output logic [SEG_W-1:0]  addr_hi_o,
  output logic [SEG_W-1:0]  idx_o,
  output logic [SEG_W-1:0]  br_rbus_o,
  output logic [PA_W-1:0]   br_ibus_o
);
  logic [SEG_W-1:0] k_w, sum_w, wb_w;
  logic [PA_W-1:0]  abus_w;
  logic [SH-1:0]    nib_q;
  logic [SEG_W-1:0] idx_q;
  logic [SEG_W-1:0] br_r_w;
  logic [PA_W-1:0]  br_i_w;

  sa_step_rom #(.W(SEG_W), .SEL_W(KSEL_W)) u_rom (
    .sel_i(ksel_i), .k_o(k_w)
  );

  sa_addr_adder #(.W(SEG_W), .SH(SH)) u_add (
    .clk(clk), .rst(rst),
    .ld_seg_i(st_start_i), .ld_upd_i(st_upd_ld_i),
    .seg_i(seg_i), .ofs_i(ofs_i), .idx_i(idx_q), .k_i(k_w),
    .sum_o(sum_w)
  );

  // Adder output lands on the internal bus shifted up; the write-back path
  // takes it down again by the same amount.
  assign abus_w = {sum_w, {SH{1'b0}}};
  assign wb_w   = abus_w[PA_W-1:SH];

  sa_bridge #(.RW(SEG_W), .SH(SH)) u_br (
    .mode_i(sa_pkg::br_mode_e'(br_mode_i)),
    .r_i(br_rbus_i), .i_i(br_ibus_i),
    .r_o(br_r_w), .i_o(br_i_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_q     <= '0;
      idx_q     <= '0;
      addr_lo_o <= '0;
      addr_hi_o <= '0;
      br_rbus_o <= '0;
      br_ibus_o <= '0;
    end else begin
      if (st_start_i) begin
        nib_q <= ofs_i[SH-1:0];
        idx_q <= ofs_i;
      end else if (st_upd_wr_i && upd_en_i) begin
        idx_q <= wb_w;
      end
      if (st_form_i) begin
        addr_hi_o <= abus_w[PA_W-1:SH];
        addr_lo_o <= nib_q;
      end
      br_rbus_o <= br_r_w;
      br_ibus_o <= br_i_w;
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/sa_seg_addr_chk.sv
module sa_seg_addr_chk #(
  parameter int SEG_W = 16,
  parameter int SH    = 4,
  parameter int KSEL_W = 3,
  localparam int PA_W = SEG_W + SH
) (
  input logic              clk,
  input logic              rst,
  input logic [SEG_W-1:0]  seg_i,
  input logic [SEG_W-1:0]  ofs_i,
  input logic              st_start_i,
  input logic              st_form_i,
  input logic              st_upd_ld_i,
  input logic              st_upd_wr_i,
  input logic              upd_en_i,
  input logic [KSEL_W-1:0] ksel_i,
  input logic [1:0]        br_mode_i,
  input logic [SEG_W-1:0]  br_rbus_i,
  input logic [PA_W-1:0]   br_ibus_i,
  input logic [SH-1:0]     addr_lo_o,
  input logic [SEG_W-1:0]  addr_hi_o,
  input logic [SEG_W-1:0]  idx_o,
  input logic [SEG_W-1:0]  br_rbus_o,
  input logic [PA_W-1:0]   br_ibus_o
);
  logic [PA_W-1:0] pa_q;
  logic            pa_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_q    <= '0;
      pa_ok_q <= 1'b0;
    end else if (st_start_i) begin
      pa_q    <= ({{SH{1'b0}}, seg_i} << SH) + {{SH{1'b0}}, ofs_i};
      pa_ok_q <= 1'b1;
    end else if (st_upd_ld_i) begin
      pa_ok_q <= 1'b0;
    end
  end

  AST_ADDR_FORMULA: assert property (@(posedge clk) disable iff (rst)
    (st_form_i && pa_ok_q && !st_start_i) |=> ({addr_hi_o, addr_lo_o} == $past(pa_q))); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !st_form_i |=> ($stable(addr_hi_o) && $stable(addr_lo_o))); // R4

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
    st_start_i |=> (idx_o == $past(ofs_i))); // R5

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!st_start_i && !(st_upd_wr_i && upd_en_i)) |=> $stable(idx_o)); // R8

  AST_BR_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (br_mode_i == 2'd0) |=> (br_rbus_o == $past(br_ibus_i[SEG_W-1:0]))); // R9

  AST_BR_SWAP: assert property (@(posedge clk) disable iff (rst)
    (br_mode_i == 2'd1) |=> (br_rbus_o == {$past(br_ibus_i[7:0]), $past(br_ibus_i[15:8])})); // R10

  AST_BR_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (br_mode_i == 2'd2) |=> (br_rbus_o == $past(br_ibus_i[PA_W-1:SH]))); // R11
endmodule

bind sa_seg_addr sa_seg_addr_chk #(.SEG_W(SEG_W), .SH(SH), .KSEL_W(KSEL_W)) chk_i (
  .clk(clk), .rst(rst), .seg_i(seg_i), .ofs_i(ofs_i),
  .st_start_i(st_start_i), .st_form_i(st_form_i),
  .st_upd_ld_i(st_upd_ld_i), .st_upd_wr_i(st_upd_wr_i),
  .upd_en_i(upd_en_i), .ksel_i(ksel_i), .br_mode_i(br_mode_i),
  .br_rbus_i(br_rbus_i), .br_ibus_i(br_ibus_i),
  .addr_lo_o(addr_lo_o), .addr_hi_o(addr_hi_o), .idx_o(idx_o),
  .br_rbus_o(br_rbus_o), .br_ibus_o(br_ibus_o)
);

// File: tb/sa_seg_addr_tb_top.sv
`timescale 1ns/1ps
module sa_seg_addr_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] seg_i = '0, ofs_i = '0;
  logic        st_start_i = 0, st_form_i = 0, st_upd_ld_i = 0, st_upd_wr_i = 0, upd_en_i = 0;
  logic [2:0]  ksel_i = '0;
  logic [1:0]  br_mode_i = '0;
  logic [15:0] br_rbus_i = '0;
  logic [19:0] br_ibus_i = '0;
  logic [3:0]  addr_lo_o;
  logic [15:0] addr_hi_o, idx_o, br_rbus_o;
  logic [19:0] br_ibus_o;

  always #2 clk = ~clk;

  sa_seg_addr dut_i (
    .clk(clk), .rst(rst), .seg_i(seg_i), .ofs_i(ofs_i),
    .st_start_i(st_start_i), .st_form_i(st_form_i),
    .st_upd_ld_i(st_upd_ld_i), .st_upd_wr_i(st_upd_wr_i),
    .upd_en_i(upd_en_i), .ksel_i(ksel_i), .br_mode_i(br_mode_i),
    .br_rbus_i(br_rbus_i), .br_ibus_i(br_ibus_i),
    .addr_lo_o(addr_lo_o), .addr_hi_o(addr_hi_o), .idx_o(idx_o),
    .br_rbus_o(br_rbus_o), .br_ibus_o(br_ibus_o)
  );

  typedef struct {
    int          due;
    int          kind;   // 0 address, 1 index, 2 reg-bus side, 3 internal side
    logic [19:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];
  int    cyc = 0;
  int    n_run = 0, n_fail = 0;
  bit    done = 0;
  logic [15:0] exp_idx = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares each due item half a period after the update edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      logic [19:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = {addr_hi_o, addr_lo_o};
        1: act = {4'h0, idx_o};
        2: act = {4'h0, br_rbus_o};
        default: act = br_ibus_o;
      endcase
      n_run++;
      if (it.due != cyc || act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d cyc=%0d: actual %h expected %h", it.req, it.kind, cyc, act, it.exp);
      end
    end
  end

  task automatic push(int due, int kind, logic [19:0] exp, string req);
    item_t it;
    it.due = due; it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic form_addr(logic [15:0] seg, logic [15:0] ofs, string req);
    logic [19:0] pa;
    @(negedge clk);
    pa = 20'(({4'h0, seg} << 4) + {4'h0, ofs});
    seg_i = seg; ofs_i = ofs; st_start_i = 1;
    exp_idx = ofs;
    push(cyc + 1, 1, {4'h0, ofs}, "R5");
    @(negedge clk);
    st_start_i = 0; st_form_i = 1;
    ofs_i = ~ofs; seg_i = ~seg;          // R3: late changes must not leak in
    push(cyc + 1, 0, pa, req);
    @(negedge clk);
    st_form_i = 0;
    push(cyc + 2, 0, pa, "R4");          // holds with no form strobe
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic update(logic [2:0] ksel, bit en, string req);
    int k;
    k = (ksel <= 3'd5) ? int'(ksel) - 3 : 0;
    @(negedge clk);
    ksel_i = ksel; st_upd_ld_i = 1;
    @(negedge clk);
    st_upd_ld_i = 0; st_upd_wr_i = 1; upd_en_i = en;
    if (en) exp_idx = 16'(int'(exp_idx) + k);
    push(cyc + 1, 1, {4'h0, exp_idx}, req);
    @(negedge clk);
    st_upd_wr_i = 0; upd_en_i = 0;
    @(negedge clk);
  endtask

  task automatic bridge(logic [1:0] mode, logic [15:0] r, logic [19:0] i,
                        logic [15:0] exp_r, logic [19:0] exp_i, string req);
    @(negedge clk);
    br_mode_i = mode; br_rbus_i = r; br_ibus_i = i;
    push(cyc + 1, 2, {4'h0, exp_r}, req);
    push(cyc + 1, 3, exp_i, req);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    n_run++;
    if ({addr_hi_o, addr_lo_o, idx_o, br_rbus_o, br_ibus_o} !== '0) begin
      n_fail++;
      $display("FAIL R1: actual %h expected 0", {addr_hi_o, addr_lo_o, idx_o, br_rbus_o, br_ibus_o});
    end
    rst = 0;
    @(negedge clk);
    push(cyc, 0, 20'h0, "R1");
    push(cyc, 1, 20'h0, "R1");

    form_addr(16'h1234, 16'h5678, "R2");   // 0x179B8
    form_addr(16'hFFFF, 16'h0010, "R2");   // wraps to 0
    form_addr(16'hF000, 16'hFFFF, "R2");   // top of space
    form_addr(16'h0000, 16'hABCD, "R3");   // nibble D from start clock

    form_addr(16'h0100, 16'h0001, "R2");
    update(3'd0, 1'b1, "R7");              // 1 - 3 wraps to FFFE (R6 code 0)
    update(3'd5, 1'b1, "R6");              // +2 -> 0000
    update(3'd5, 1'b1, "R7");              // +2 -> 0002
    update(3'd4, 1'b0, "R8");              // no enable, unchanged
    update(3'd7, 1'b1, "R6");              // code 7 gives 0
    update(3'd2, 1'b1, "R6");              // -1 -> 0001

    form_addr(16'h0000, 16'hFFFF, "R2");
    update(3'd5, 1'b1, "R7");              // FFFF + 2 wraps to 0001

    bridge(2'd0, 16'h1234, 20'hA5678, 16'h5678, 20'h01234, "R9");
    bridge(2'd1, 16'h1234, 20'hA5678, 16'h7856, 20'h03412, "R10");
    bridge(2'd2, 16'h1234, 20'hA5678, 16'hA567, 20'h12340, "R11");
    bridge(2'd3, 16'hBEEF, 20'h3C0DE, 16'hC0DE, 20'h0BEEF, "R9");

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule